// File: doc/BRIEF.md
# Prescaled 54-bit Alarm Timer

This block is one general-purpose timer for a memory-mapped register interface. A programmable prescaler divides the system clock. Each divided tick moves a 54-bit counter one step up or down. A comparator checks the counter against a 64-bit alarm value. On a match, the timer raises a one-cycle event and latches an interrupt status bit. It can also reload the counter from a programmed reload value.

Software reads the count through a snapshot handshake. A write to the request register marks the snapshot busy. The live count is copied into two readable words after a fixed latency, which stands in for a clock-domain crossing. The busy bit then drops.

Next to the register controls, five hardware task inputs let an external event-routing fabric start, stop, arm, reload or capture the timer. All logic runs on one clock with a synchronous active-low reset.

Top module: `gp_alarm_timer`

Register map, by word address on `bus_addr`:

| Address | Name | Content |
|---|---|---|
| 0 | CTRL | bit0 run, bit1 up, bit2 arm, bit3 auto-reload |
| 1 | DIV | [15:0] divide field |
| 2 | ALARM low | alarm value bits 31:0 |
| 3 | ALARM high | alarm value bits 63:32 |
| 4 | RELOAD low | reload value bits 31:0 |
| 5 | RELOAD high | [21:0] reload value bits 53:32 |
| 6 | SNAP_REQ | write bit0 to request a snapshot; read bit0 is busy |
| 7 | SNAP low | snapshot bits 31:0 |
| 8 | SNAP high | [21:0] snapshot bits 53:32 |
| 9 | LOAD | write bit0 to load the reload value |
| 10 | INT_EN | bit0 interrupt enable |
| 11 | INT_RAW | bit0 raw alarm status |
| 12 | INT_CLR | write bit0 to clear the status |

Reads of any other address return 0.

## Requirements
- R1: After reset the following values hold: counter 0, divide field 2, CTRL reads 0, snapshot words 0, snapshot not busy, interrupt enable 0, raw status 0, and `irq` and `alarm_evt` low.
- R2: While run (CTRL bit0) is set, the counter steps once every N clocks, where N is the DIV field. A field of 0 means N = 65536, and a field of 1 behaves as N = 2.
- R3: Any write to DIV (address 1) restarts the divider phase. The next step after such a write comes exactly N clocks after the write edge.
- R4: On a step, the counter adds one when up (CTRL bit1) is set and subtracts one when it is clear, wrapping modulo 2^54.
- R5: `alarm_evt` is high in every cycle where arm (CTRL bit2) is set and the zero-extended counter equals the 64-bit alarm value. At that edge arm clears itself, and this takes priority over a CTRL write or an arm task in the same cycle.
- R6: When auto-reload (CTRL bit3) is set, an alarm edge loads the reload value into the counter instead of stepping.
- R7: Writing bit0 = 1 to LOAD (address 9), or pulsing `task_reload`, puts the reload value into the counter at that edge. This overrides both alarm reload and stepping.
- R8: Writing bit0 = 1 to SNAP_REQ (address 6), or pulsing `task_capture`, makes SNAP_REQ bit0 read 1 for SYNC_LAT cycles. At the edge where busy clears, the snapshot words take the live count. Requests made while busy are ignored.
- R9: Raw status (INT_RAW bit0) sets on every alarm edge, whatever the enable. Writing bit0 = 1 to INT_CLR clears it, but a clear and an alarm in the same cycle leave it set. `irq` equals raw status AND INT_EN bit0.
- R10: `task_start` sets run and `task_stop` clears it, with stop winning when both pulse together. `task_arm` sets arm. A CTRL write in the same cycle overrides all tasks.
- R11: The snapshot reads as a low 32-bit word (address 7) and a high word (address 8) holding count bits 53:32 in bits 21:0, with the upper bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address, also selects read data |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| task_start | input | 1 | Hardware task: set run |
| task_stop | input | 1 | Hardware task: clear run |
| task_arm | input | 1 | Hardware task: set arm |
| task_reload | input | 1 | Hardware task: load reload value |
| task_capture | input | 1 | Hardware task: request snapshot |
| alarm_evt | output | 1 | One-cycle alarm match event |
| irq | output | 1 | Interrupt line, raw status AND enable |

## Verification
A prescaler phase that has drifted shows within one divide period: the counter then steps a cycle early or late, and the next snapshot or alarm event is off. A wrong counter or arm state first shows on `alarm_evt`, in the cycle a match should or should not occur. A stale snapshot shows as soon as the busy bit drops and the snapshot words are read. Because the reference model is compared on every clock while the read address sweeps the whole map, any divergence is reported in the cycle it first reaches a port.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
// Package: register word addresses and control bit positions shared by the
// timer top level and its bench. Assumes a 4-bit word address.
package tmr_pkg;
    typedef enum logic [3:0] {
        A_CTRL     = 4'd0,
        A_DIV      = 4'd1,
        A_ALM_LO   = 4'd2,
        A_ALM_HI   = 4'd3,
        A_RLD_LO   = 4'd4,
        A_RLD_HI   = 4'd5,
        A_SNAP_REQ = 4'd6,
        A_SNAP_LO  = 4'd7,
        A_SNAP_HI  = 4'd8,
        A_LOAD     = 4'd9,
        A_INT_EN   = 4'd10,
        A_INT_RAW  = 4'd11,
        A_INT_CLR  = 4'd12
    } reg_addr_e;

    localparam int CTL_RUN = 0;
    localparam int CTL_UP  = 1;
    localparam int CTL_ARM = 2;
    localparam int CTL_AR  = 3;
endpackage

// File: rtl/tmr_prescaler.sv
`timescale 1ns/1ps
// Module: tmr_prescaler
// Emits a one-cycle tick every N enabled clocks, where N comes from the
// divide field. A field of 0 means 2**DIV_W, and a field of 1 is raised to 2.
// Assumes restart is a single-cycle strobe from a divide-field write.
module tmr_prescaler #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [DIV_W-1:0] div_field,
    output logic             tick
);
    logic [DIV_W-1:0] phase_q;
    logic [DIV_W-1:0] last_phase;

    // Map the divide field to the terminal phase value (N-1).
    always_comb begin
        if (div_field == '0)
            last_phase = '1;
        else if (div_field == DIV_W'(1))
            last_phase = DIV_W'(1);
        else
            last_phase = div_field - DIV_W'(1);
    end

    assign tick = run && (phase_q == last_phase);

    // Phase counter: cleared by restart, advances only while running.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= '0;
        else if (restart)
            phase_q <= '0;
        else if (run)
            phase_q <= tick ? '0 : phase_q + DIV_W'(1);
    end

    // R3
    phase_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !tick);
endmodule

// File: rtl/tmr_snapshot.sv
`timescale 1ns/1ps
// Module: tmr_snapshot
// Models the register-side copy of the live count. A request marks the
// block busy. LAT edges later the live value is latched and busy drops.
// Assumes LAT >= 1. Requests made while busy are dropped.
module tmr_snapshot #(
    parameter int W   = 54,
    parameter int LAT = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req,
    input  logic [W-1:0] live,
    output logic         busy,
    output logic [W-1:0] snap
);
    localparam int DLY_W = (LAT < 2) ? 1 : $clog2(LAT);

    logic [DLY_W-1:0] dly_q;

    // Busy/delay sequencer and snapshot latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            dly_q <= '0;
            snap  <= '0;
        end else if (busy) begin
            if (dly_q == '0) begin
                snap <= live;
                busy <= 1'b0;
            end else begin
                dly_q <= dly_q - DLY_W'(1);
            end
        end else if (req) begin
            busy  <= 1'b1;
            dly_q <= DLY_W'(LAT - 1);
        end
    end

    // R8
    snap_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> snap == $past(live));
endmodule

// File: rtl/tmr_counter.sv
`timescale 1ns/1ps
// Module: tmr_counter
// Holds the up/down count and the alarm comparator. Update priority is
// explicit load, then alarm auto-reload, then a prescaler step.
// Assumes ALM_W >= W so that the count compares zero-extended.
module tmr_counter #(
    parameter int W     = 54,
    parameter int ALM_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             up,
    input  logic             load,
    input  logic             armed,
    input  logic             autoreload,
    input  logic [W-1:0]     reload_val,
    input  logic [ALM_W-1:0] alarm_val,
    output logic             hit,
    output logic [W-1:0]     cnt
);
    localparam int PAD = ALM_W - W;

    assign hit = armed && ({{PAD{1'b0}}, cnt} == alarm_val);

    // Count register with load / reload / step priority.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load || (hit && autoreload))
            cnt <= reload_val;
        else if (tick)
            cnt <= up ? cnt + W'(1) : cnt - W'(1);
    end

    // R4
    step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && up && !load && !(hit && autoreload)) |=> cnt == $past(cnt) + W'(1));
    // R4
    step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !up && !load && !(hit && autoreload)) |=> cnt == $past(cnt) - W'(1));
    // R7
    force_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt == $past(reload_val));
    // R6
    auto_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && autoreload) |=> cnt == $past(reload_val));
endmodule

// File: rtl/gp_alarm_timer.sv
`timescale 1ns/1ps
// Module: gp_alarm_timer
// A single prescaled up/down alarm timer with a register file, a snapshot
// handshake, hardware task inputs and a maskable alarm interrupt.
// Assumes one clock for registers and counter, and 33 <= CNT_W <= 63.
module gp_alarm_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W    = 54,
    parameter int DIV_W    = 16,
    parameter int SYNC_LAT = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [3:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        task_start,
    input  logic        task_stop,
    input  logic        task_arm,
    input  logic        task_reload,
    input  logic        task_capture,
    output logic        alarm_evt,
    output logic        irq
);
    localparam int HI_W  = CNT_W - 32;
    localparam int ALM_W = 64;

    logic             run_q, up_q, arm_q, ar_q, ien_q, raw_q;
    logic [DIV_W-1:0] div_q;
    logic [ALM_W-1:0] alm_q;
    logic [CNT_W-1:0] rld_q;
    logic             wr_ctrl, wr_div, do_load, snap_req, clr_req;
    logic             tick, hit, snap_busy;
    logic [CNT_W-1:0] cnt, snap;

    assign wr_ctrl  = bus_wr && (bus_addr == A_CTRL);
    assign wr_div   = bus_wr && (bus_addr == A_DIV);
    assign do_load  = (bus_wr && (bus_addr == A_LOAD) && bus_wdata[0]) || task_reload;
    assign snap_req = (bus_wr && (bus_addr == A_SNAP_REQ) && bus_wdata[0]) || task_capture;
    assign clr_req  = bus_wr && (bus_addr == A_INT_CLR) && bus_wdata[0];

    // Configuration registers written directly by the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            up_q  <= 1'b0;
            ar_q  <= 1'b0;
            ien_q <= 1'b0;
            div_q <= DIV_W'(2);
            alm_q <= '0;
            rld_q <= '0;
        end else if (bus_wr) begin
            case (reg_addr_e'(bus_addr))
                A_CTRL:   begin up_q <= bus_wdata[CTL_UP]; ar_q <= bus_wdata[CTL_AR]; end
                A_DIV:    div_q <= bus_wdata[DIV_W-1:0];
                A_ALM_LO: alm_q[31:0] <= bus_wdata;
                A_ALM_HI: alm_q[63:32] <= bus_wdata;
                A_RLD_LO: rld_q[31:0] <= bus_wdata;
                A_RLD_HI: rld_q[CNT_W-1:32] <= bus_wdata[HI_W-1:0];
                A_INT_EN: ien_q <= bus_wdata[0];
                default:  ;
            endcase
        end
    end

    // Run bit: bus write, then stop task, then start task.
    always_ff @(posedge clk) begin
        if (!rst_n)          run_q <= 1'b0;
        else if (wr_ctrl)    run_q <= bus_wdata[CTL_RUN];
        else if (task_stop)  run_q <= 1'b0;
        else if (task_start) run_q <= 1'b1;
    end

    // Arm bit: self-clears on a hit, else bus write, else arm task.
    always_ff @(posedge clk) begin
        if (!rst_n)        arm_q <= 1'b0;
        else if (hit)      arm_q <= 1'b0;
        else if (wr_ctrl)  arm_q <= bus_wdata[CTL_ARM];
        else if (task_arm) arm_q <= 1'b1;
    end

    // Raw interrupt status: a hit wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)       raw_q <= 1'b0;
        else if (hit)     raw_q <= 1'b1;
        else if (clr_req) raw_q <= 1'b0;
    end

    tmr_prescaler #(.DIV_W(DIV_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .run(run_q), .restart(wr_div),
        .div_field(div_q), .tick(tick)
    );

    tmr_counter #(.W(CNT_W), .ALM_W(ALM_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .up(up_q), .load(do_load),
        .armed(arm_q), .autoreload(ar_q), .reload_val(rld_q),
        .alarm_val(alm_q), .hit(hit), .cnt(cnt)
    );

    tmr_snapshot #(.W(CNT_W), .LAT(SYNC_LAT)) u_snap (
        .clk(clk), .rst_n(rst_n), .req(snap_req), .live(cnt),
        .busy(snap_busy), .snap(snap)
    );

    assign alarm_evt = hit;
    assign irq       = raw_q && ien_q;

    // Read data multiplexer.
    always_comb begin
        bus_rdata = '0;
        case (reg_addr_e'(bus_addr))
            A_CTRL:     bus_rdata = {28'd0, ar_q, arm_q, up_q, run_q};
            A_DIV:      bus_rdata = {{(32-DIV_W){1'b0}}, div_q};
            A_ALM_LO:   bus_rdata = alm_q[31:0];
            A_ALM_HI:   bus_rdata = alm_q[63:32];
            A_RLD_LO:   bus_rdata = rld_q[31:0];
            A_RLD_HI:   bus_rdata = {{(32-HI_W){1'b0}}, rld_q[CNT_W-1:32]};
            A_SNAP_REQ: bus_rdata = {31'd0, snap_busy};
            A_SNAP_LO:  bus_rdata = snap[31:0];
            A_SNAP_HI:  bus_rdata = {{(32-HI_W){1'b0}}, snap[CNT_W-1:32]};
            A_INT_EN:   bus_rdata = {31'd0, ien_q};
            A_INT_RAW:  bus_rdata = {31'd0, raw_q};
            default:    bus_rdata = '0;
        endcase
    end

    // R5
    alarm_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_evt |=> !arm_q);
    // R9
    raw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_evt |=> raw_q);
    // R10
    task_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (task_stop && !wr_ctrl) |=> !run_q);
endmodule

// File: tb/gp_alarm_timer_tb_top.sv
`timescale 1ns/1ps
// Bench: behavioural cycle model of the timer, compared with the DUT each cycle.
module gp_alarm_timer_tb_top;
    import tmr_pkg::*;

    localparam int LAT = 3;
    localparam int CW  = 54;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        task_start = 1'b0, task_stop = 1'b0, task_arm = 1'b0;
    logic        task_reload = 1'b0, task_capture = 1'b0;
    logic        alarm_evt, irq;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    gp_alarm_timer #(.CNT_W(CW), .DIV_W(16), .SYNC_LAT(LAT)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .task_start(task_start), .task_stop(task_stop), .task_arm(task_arm),
        .task_reload(task_reload), .task_capture(task_capture),
        .alarm_evt(alarm_evt), .irq(irq)
    );

    // ---------------- reference model state ----------------
    bit          m_run, m_up, m_arm, m_ar, m_ien, m_raw, m_busy;
    int          m_phase, m_dly;
    logic [15:0] m_div;
    logic [63:0] m_alm;
    logic [CW-1:0] m_rld, m_cnt, m_snap;

    function automatic int term_phase(input logic [15:0] f);
        if (f == 16'd0) return 65535;
        if (f == 16'd1) return 1;
        return int'(f) - 1;
    endfunction

    function automatic bit m_hit();
        return m_arm && ({10'd0, m_cnt} == m_alm);
    endfunction

    function automatic logic [31:0] m_read(input logic [3:0] a);
        case (a)
            4'd0:  return {28'd0, m_ar, m_arm, m_up, m_run};
            4'd1:  return {16'd0, m_div};
            4'd2:  return m_alm[31:0];
            4'd3:  return m_alm[63:32];
            4'd4:  return m_rld[31:0];
            4'd5:  return {10'd0, m_rld[53:32]};
            4'd6:  return {31'd0, m_busy};
            4'd7:  return m_snap[31:0];
            4'd8:  return {10'd0, m_snap[53:32]};
            4'd10: return {31'd0, m_ien};
            4'd11: return {31'd0, m_raw};
            default: return 32'd0;
        endcase
    endfunction

    function automatic string tag_of(input logic [3:0] a);
        case (a)
            4'd0: return "R10";
            4'd1: return "R2";
            4'd2, 4'd3: return "R5";
            4'd4, 4'd5: return "R6";
            4'd6: return "R8";
            4'd7, 4'd8: return "R11";
            default: return "R9";
        endcase
    endfunction

    // Model update on each rising edge, from the inputs and old model state.
    always @(posedge clk) begin : model_step
        bit hit, tick, wctl, ld, req, clr;
        logic [CW-1:0] cnt_old;
        if (!rst_n) begin
            m_run = 0; m_up = 0; m_arm = 0; m_ar = 0; m_ien = 0; m_raw = 0;
            m_busy = 0; m_phase = 0; m_dly = 0; m_div = 16'd2;
            m_alm = '0; m_rld = '0; m_cnt = '0; m_snap = '0;
        end else begin
            hit     = m_hit();
            tick    = m_run && (m_phase == term_phase(m_div));
            wctl    = bus_wr && bus_addr == 4'd0;
            ld      = (bus_wr && bus_addr == 4'd9 && bus_wdata[0]) || task_reload;
            req     = (bus_wr && bus_addr == 4'd6 && bus_wdata[0]) || task_capture;
            clr     = bus_wr && bus_addr == 4'd12 && bus_wdata[0];
            cnt_old = m_cnt;
            // counter
            if (ld || (hit && m_ar)) m_cnt = m_rld;
            else if (tick) m_cnt = m_up ? m_cnt + 1'b1 : m_cnt - 1'b1;
            // prescaler phase
            if (bus_wr && bus_addr == 4'd1) m_phase = 0;
            else if (m_run) m_phase = tick ? 0 : m_phase + 1;
            // snapshot
            if (m_busy) begin
                if (m_dly == 0) begin m_snap = cnt_old; m_busy = 0; end
                else m_dly--;
            end else if (req) begin
                m_busy = 1; m_dly = LAT - 1;
            end
            // status
            if (hit) m_raw = 1; else if (clr) m_raw = 0;
            // arm / run
            if (hit) m_arm = 0; else if (wctl) m_arm = bus_wdata[2]; else if (task_arm) m_arm = 1;
            if (wctl) m_run = bus_wdata[0]; else if (task_stop) m_run = 0; else if (task_start) m_run = 1;
            // registers
            if (bus_wr) begin
                case (bus_addr)
                    4'd0:  begin m_up = bus_wdata[1]; m_ar = bus_wdata[3]; end
                    4'd1:  m_div = bus_wdata[15:0];
                    4'd2:  m_alm[31:0] = bus_wdata;
                    4'd3:  m_alm[63:32] = bus_wdata;
                    4'd4:  m_rld[31:0] = bus_wdata;
                    4'd5:  m_rld[53:32] = bus_wdata[21:0];
                    4'd10: m_ien = bus_wdata[0];
                    default: ;
                endcase
            end
        end
    end

    // Mid-cycle comparison of every output against the model.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            vectors++;
            if (alarm_evt !== m_hit()) begin
                errors++;
                $display("FAIL R5 alarm_evt act=%0b exp=%0b t=%0t", alarm_evt, m_hit(), $time);
            end
            if (irq !== (m_raw && m_ien)) begin
                errors++;
                $display("FAIL R9 irq act=%0b exp=%0b t=%0t", irq, m_raw && m_ien, $time);
            end
            if (bus_rdata !== m_read(bus_addr)) begin
                errors++;
                $display("FAIL %s rdata@%0d act=%h exp=%h t=%0t", tag_of(bus_addr),
                         bus_addr, bus_rdata, m_read(bus_addr), $time);
            end
        end
    end

    // ---------------- stimulus helpers (called at posedge + 1) ----------------
    task automatic cyc(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        cyc(1);
        bus_wr = 1'b0;
    endtask

    task automatic pulse(input int which);
        case (which)
            0: task_start = 1'b1;
            1: task_stop = 1'b1;
            2: task_arm = 1'b1;
            3: task_reload = 1'b1;
            default: task_capture = 1'b1;
        endcase
        cyc(1);
        {task_start, task_stop, task_arm, task_reload, task_capture} = '0;
    endtask

    // Directed read with a fixed expectation.
    task automatic expect_rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a;
        @(negedge clk); #0.1;
        vectors++;
        if (bus_rdata !== exp) begin
            errors++;
            $display("FAIL %s directed read @%0d act=%h exp=%h", tag, a, bus_rdata, exp);
        end
        @(posedge clk); #1;
    endtask

    task automatic snapshot();
        wr(4'd6, 32'd1);
        cyc(LAT);
    endtask

    // Watchdog: a hang counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        cyc(4);
        rst_n = 1'b1;
        cyc(1);
        // R1 reset state
        expect_rd(4'd0, 32'd0, "R1");
        expect_rd(4'd1, 32'd2, "R1");
        expect_rd(4'd6, 32'd0, "R1");
        expect_rd(4'd7, 32'd0, "R1");
        expect_rd(4'd11, 32'd0, "R1");

        // R7 software load with the counter stopped, read back via R11 words
        wr(4'd4, 32'h1234_5678);
        wr(4'd5, 32'h0000_0015);
        wr(4'd9, 32'd1);
        snapshot();
        expect_rd(4'd7, 32'h1234_5678, "R7");
        expect_rd(4'd8, 32'h0000_0015, "R11");

        // R8 busy visible right after the request
        wr(4'd6, 32'd1);
        expect_rd(4'd6, 32'd1, "R8");
        cyc(LAT);

        // R4 down-count wrap below zero
        wr(4'd4, 32'd0);
        wr(4'd5, 32'd0);
        wr(4'd9, 32'd1);
        wr(4'd0, 32'h1);           // run, down, divide 2
        cyc(5);
        wr(4'd0, 32'h0);
        snapshot();
        expect_rd(4'd8, 32'h003F_FFFF, "R4");

        // R2/R3 divide 4, mid-phase rewrite restarts phase
        wr(4'd9, 32'd1);
        wr(4'd1, 32'd4);
        wr(4'd0, 32'h3);           // run, up
        cyc(2);
        wr(4'd1, 32'd4);           // R3 restart
        cyc(9);
        wr(4'd0, 32'h2);
        snapshot();
        bus_addr = 4'd7; cyc(2);   // compared by the model (R3)

        // R5/R6/R9 alarm with auto-reload and interrupt
        wr(4'd1, 32'd2);
        wr(4'd4, 32'd3);
        wr(4'd9, 32'd1);
        wr(4'd2, 32'd10);
        wr(4'd3, 32'd0);
        wr(4'd10, 32'd1);
        wr(4'd0, 32'hF);           // run, up, arm, auto-reload
        bus_addr = 4'd11;
        cyc(40);
        expect_rd(4'd11, 32'd1, "R9");
        expect_rd(4'd0, 32'hB, "R5");   // arm cleared by the alarm
        wr(4'd12, 32'd1);
        expect_rd(4'd11, 32'd0, "R9");

        // R10 tasks
        pulse(1);
        expect_rd(4'd0, 32'hA, "R10");
        pulse(0);
        pulse(2);
        cyc(30);
        pulse(4);
        cyc(LAT + 1);
        pulse(3);

        // Mixed random traffic, model-checked every cycle
        for (int i = 0; i < 3000; i++) begin
            int op;
            op = $urandom_range(0, 13);
            case (op)
                0: wr(4'd0, $urandom_range(0, 15));
                1: wr(4'd1, $urandom_range(0, 4) == 0 ? 32'd0 : $urandom_range(1, 5));
                2: wr(4'd2, $urandom_range(0, 40));
                3: wr(4'd3, $urandom_range(0, 7) == 0 ? 32'd1 : 32'd0);
                4: wr(4'd4, $urandom_range(0, 30));
                5: wr(4'd9, 32'd1);
                6: wr(4'd6, 32'd1);
                7: wr(4'd10, $urandom_range(0, 1));
                8: wr(4'd12, 32'd1);
                9: pulse($urandom_range(0, 4));
                default: begin bus_addr = 4'($urandom_range(0, 13)); cyc(1); end
            endcase
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule